// File: doc/BRIEF.md
# Double-Buffered PWM Channel

This block is one pulse-width modulation channel with its own register window. A prescaler divides the system clock and feeds a period counter. The counter's value is compared against an active width value to drive an output flip-flop, and a polarity bit selects a high-going or a low-going pulse on the pin. Software writes new period and width values into first-stage buffers. The block moves them into the active registers only when the counter rolls over, so the waveform changes only at a period boundary. A transparent mode bit skips the buffering, and the new value then takes effect at once.

When generation is switched off, the counters stop and the channel becomes a plain I/O pin. A direction bit decides whether the pin drives. If it drives, the level comes from the polarity bit. A global freeze line stops all counting, but only when the channel's freeze-enable bit is set. A read-only status bit always shows the level on the pin.

Top module: `pwmch_top`

## Requirements
- R1: The prescaler is an 8-bit up-counter. It reloads from the preload field (control bits [7:0]) when it steps past 0xFF, and that step issues one tick. The divide ratio is therefore 256 minus the preload, and a preload of 0xFF gives a tick on every clock.
- R2: A write to address 0 (period) or address 1 (width) updates only the first-stage buffer, which reads back at the same address. The active period and width take the buffer values only at a period rollover.
- R3: While the transparent bit (control bit 11) is 1, a period or width write also becomes the active value at the same clock edge.
- R4: While the freeze-enable bit (control bit 12) and freezeIn are both 1, the prescaler, the counter and the output flip-flop hold. While freeze-enable is 0, freezeIn has no effect.
- R5: On each tick, the counter (read at address 2) steps 1, 2, … and rolls over to 1 when it is 0 or has reached the active period. The output flip-flop is active while the counter is between 1 and the active width, so a period lasts P ticks and the pulse lasts W ticks. Writes to address 2 have no effect.
- R6: An active width of 0 gives a constantly inactive output. A width equal to or greater than the period gives a constantly active output.
- R7: With the enable bit (control bit 8) set to 1, oe is 1. pinOut equals the flip-flop when the polarity bit (control bit 9) is 1 and its inverse when the polarity bit is 0. The direction bit has no effect in this state.
- R8: With the enable bit set to 0, the counter reads 0, the flip-flop clears, and oe equals the direction bit (control bit 10, where 1 means output). pinOut then equals the polarity bit.
- R9: Control bit 15 reads the current pinIn level. Writing that bit has no effect.
- R10: After reset, all registers read 0, oe is 0 and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 period, 1 width, 2 counter, 3 control |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr, combinational |
| freezeIn | input | 1 | Global freeze request |
| pinIn | input | 1 | Level seen on the pin |
| pinOut | output | 1 | Level driven to the pin |
| oe | output | 1 | Pin output enable |

## Verification
The assertions assume that reset is applied before the first edge, that the write strobe and address are stable across each rising edge, and that freezeIn is synchronous to clk. The bench changes every input only on the falling edge and applies reset at time zero. It never leaves the write strobe asserted for longer than the intended cycle. The random phase keeps the preload field close to 0xFF, so ticks arrive often and rollovers, buffer transfers and width-versus-period edge cases all happen within the run.

// File: rtl/pwmch_pkg.sv
package pwmch_pkg;

  typedef struct packed {
    logic en;
    logic pol;
    logic dir;
    logic transp;
    logic frzEn;
  } pwmCfg_t;

  typedef struct packed {
    logic run;
    logic tick;
    logic disabled;
    logic wrPeriod;
    logic wrWidth;
    logic transparent;
  } pwmStrobe_t;

  localparam int unsigned BIT_EN     = 8;
  localparam int unsigned BIT_POL    = 9;
  localparam int unsigned BIT_DIR    = 10;
  localparam int unsigned BIT_TRANSP = 11;
  localparam int unsigned BIT_FRZEN  = 12;
  localparam int unsigned BIT_PIN    = 15;

endpackage

// File: rtl/pwmch_ctrl.sv
module pwmch_ctrl
  import pwmch_pkg::*;
#(
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              freezeIn,
  output pwmCfg_t           cfg,
  output logic [PSC_W-1:0]  preload,
  output pwmStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_WIDTH  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(3);
  localparam logic [PSC_W-1:0]  PSC_TOP     = '1;

  logic [PSC_W-1:0] psc;
  logic             run;
  logic             tick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preload <= '0;
      cfg     <= '0;
    end else if (regWrEn && regAddr == ADDR_CTRL) begin
      preload    <= regWrData[PSC_W-1:0];
      cfg.en     <= regWrData[BIT_EN];
      cfg.pol    <= regWrData[BIT_POL];
      cfg.dir    <= regWrData[BIT_DIR];
      cfg.transp <= regWrData[BIT_TRANSP];
      cfg.frzEn  <= regWrData[BIT_FRZEN];
    end
  end

  assign run  = cfg.en && !(cfg.frzEn && freezeIn);
  assign tick = run && (psc == PSC_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psc <= '0;
    end else if (!cfg.en) begin
      psc <= preload;
    end else if (run) begin
      psc <= tick ? preload : psc + PSC_W'(1);
    end
  end

  always_comb begin
    strobe.run         = run;
    strobe.tick        = tick;
    strobe.disabled    = !cfg.en;
    strobe.wrPeriod    = regWrEn && regAddr == ADDR_PERIOD;
    strobe.wrWidth     = regWrEn && regAddr == ADDR_WIDTH;
    strobe.transparent = cfg.transp;
  end

  // R1: a tick reloads the prescaler from the preload value
  a_r1_reload: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> psc == $past(preload));

  // R4: while frozen, the prescaler holds its value
  a_r4_freeze_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.frzEn && freezeIn) |=> $stable(psc));

endmodule

// File: rtl/pwmch_datapath.sv
module pwmch_datapath
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] periodBuf,
  output logic [CNT_W-1:0] widthBuf,
  output logic [CNT_W-1:0] cnt,
  output logic             outFf
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] periodAct;
  logic [CNT_W-1:0] widthAct;
  logic             rollover;
  logic             trPeriod;
  logic             trWidth;
  logic [CNT_W-1:0] nextPeriod;
  logic [CNT_W-1:0] nextWidth;

  assign rollover   = strobe.tick && (cnt == '0 || cnt >= periodAct);
  assign trPeriod   = strobe.wrPeriod && strobe.transparent;
  assign trWidth    = strobe.wrWidth && strobe.transparent;
  assign nextPeriod = trPeriod ? wrData : periodBuf;
  assign nextWidth  = trWidth ? wrData : widthBuf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodBuf <= '0;
      widthBuf  <= '0;
    end else begin
      if (strobe.wrPeriod) periodBuf <= wrData;
      if (strobe.wrWidth)  widthBuf  <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodAct <= '0;
      widthAct  <= '0;
    end else if (rollover) begin
      periodAct <= nextPeriod;
      widthAct  <= nextWidth;
    end else begin
      if (trPeriod) periodAct <= wrData;
      if (trWidth)  widthAct  <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      outFf <= 1'b0;
    end else if (strobe.disabled) begin
      cnt   <= '0;
      outFf <= 1'b0;
    end else if (rollover) begin
      cnt   <= CNT_ONE;
      outFf <= (nextWidth != '0);
    end else if (strobe.tick) begin
      cnt <= cnt + CNT_ONE;
      if (cnt == widthAct) outFf <= 1'b0;
    end
  end

  // R2: a buffered write leaves the active period alone until rollover
  a_r2_buffer_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrPeriod && !strobe.transparent && !rollover) |=> $stable(periodAct));

  // R5: a rollover restarts the count at 1
  a_r5_restart: assert property (@(posedge clk) disable iff (!rstN)
    (rollover && !strobe.disabled) |=> cnt == CNT_ONE);

  // R6: the level at period start follows the freshly loaded width
  a_r6_start_level: assert property (@(posedge clk) disable iff (!rstN)
    (rollover && !strobe.disabled) |=> outFf == (widthAct != '0));

  // R8: a disabled channel idles with a cleared counter and flop
  a_r8_idle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.disabled |=> (cnt == '0 && !outFf));

endmodule

// File: rtl/pwmch_top.sv
module pwmch_top
  import pwmch_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PSC_W  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  regWrData,
  output logic [CNT_W-1:0]  regRdData,
  input  logic              freezeIn,
  input  logic              pinIn,
  output logic              pinOut,
  output logic              oe
);

  pwmCfg_t          cfg;
  pwmStrobe_t       strobe;
  logic [PSC_W-1:0] preload;
  logic [CNT_W-1:0] periodBuf;
  logic [CNT_W-1:0] widthBuf;
  logic [CNT_W-1:0] cnt;
  logic             outFf;
  logic [CNT_W-1:0] ctrlWord;

  pwmch_ctrl #(.PSC_W(PSC_W), .DATA_W(CNT_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .freezeIn  (freezeIn),
    .cfg       (cfg),
    .preload   (preload),
    .strobe    (strobe)
  );

  pwmch_datapath #(.CNT_W(CNT_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .periodBuf (periodBuf),
    .widthBuf  (widthBuf),
    .cnt       (cnt),
    .outFf     (outFf)
  );

  always_comb begin
    ctrlWord                = '0;
    ctrlWord[PSC_W-1:0]     = preload;
    ctrlWord[BIT_EN]        = cfg.en;
    ctrlWord[BIT_POL]       = cfg.pol;
    ctrlWord[BIT_DIR]       = cfg.dir;
    ctrlWord[BIT_TRANSP]    = cfg.transp;
    ctrlWord[BIT_FRZEN]     = cfg.frzEn;
    ctrlWord[BIT_PIN]       = pinIn;
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(0): regRdData = periodBuf;
      ADDR_W'(1): regRdData = widthBuf;
      ADDR_W'(2): regRdData = cnt;
      default:    regRdData = ctrlWord;
    endcase
  end

  assign oe     = cfg.en | cfg.dir;
  assign pinOut = cfg.en ? (cfg.pol ? outFf : ~outFf) : cfg.pol;

  // R4: a frozen, enabled channel keeps its counter value
  a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.en && cfg.frzEn && freezeIn) |=> $stable(cnt));

endmodule

// File: tb/sim_pwmch_top.sv
module sim_pwmch_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        freezeIn = 1'b0;
  logic        pinIn;
  logic        pinOut;
  logic        oe;
  logic        extLvl = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  string curReq = "R10";
  bit done = 1'b0;

  // bench model state
  logic [7:0]  mPsc = 0, mPre = 0;
  logic [15:0] mCnt = 0, mPer = 0, mWid = 0, mPerBuf = 0, mWidBuf = 0;
  logic        mFf = 0, mEn = 0, mPol = 0, mDir = 0, mTr = 0, mFz = 0;

  always #10 clk = ~clk;

  assign pinIn = oe ? pinOut : extLvl;

  pwmch_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .freezeIn(freezeIn),
    .pinIn(pinIn), .pinOut(pinOut), .oe(oe)
  );

  function automatic logic expOe();
    return mEn | mDir;
  endfunction

  function automatic logic expPin();
    return mEn ? (mPol ? mFf : ~mFf) : mPol;
  endfunction

  function automatic logic [15:0] expRead(input logic [1:0] a);
    logic [15:0] w;
    logic pinLvl;
    pinLvl = expOe() ? expPin() : extLvl;
    case (a)
      2'd0: return mPerBuf;
      2'd1: return mWidBuf;
      2'd2: return mCnt;
      default: begin
        w = '0;
        w[7:0] = mPre; w[8] = mEn; w[9] = mPol; w[10] = mDir;
        w[11] = mTr; w[12] = mFz; w[15] = pinLvl;
        return w;
      end
    endcase
  endfunction

  // advance the model by one clock edge, using pre-edge state and current inputs
  task automatic modelStep(input logic wr, input logic [1:0] a, input logic [15:0] d, input logic fz);
    logic run, tick, roll, wP, wW;
    logic [15:0] newPer, newWid;
    run  = mEn && !(mFz && fz);
    tick = run && mPsc == 8'hFF;
    wP = wr && a == 2'd0;
    wW = wr && a == 2'd1;
    roll = tick && (mCnt == 0 || mCnt >= mPer);
    newPer = (wP && mTr) ? d : mPerBuf;
    newWid = (wW && mTr) ? d : mWidBuf;
    if (!mEn) begin
      mCnt = 0; mFf = 0;
    end else if (roll) begin
      mCnt = 1; mFf = (newWid != 0);
    end else if (tick) begin
      if (mCnt == mWid) mFf = 0;
      mCnt = mCnt + 1;
    end
    if (roll) begin
      mPer = newPer; mWid = newWid;
    end else begin
      if (wP && mTr) mPer = d;
      if (wW && mTr) mWid = d;
    end
    if (!mEn) mPsc = mPre;
    else if (run) mPsc = tick ? mPre : mPsc + 8'd1;
    if (wP) mPerBuf = d;
    if (wW) mWidBuf = d;
    if (wr && a == 2'd3) begin
      mPre = d[7:0]; mEn = d[8]; mPol = d[9]; mDir = d[10]; mTr = d[11]; mFz = d[12];
    end
  endtask

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input logic wr, input logic [1:0] a, input logic [15:0] d, input logic [1:0] rdA);
    regWrEn = wr; regAddr = wr ? a : rdA; regWrData = d;
    @(posedge clk);
    modelStep(wr, a, d, freezeIn);
    @(negedge clk);
    regWrEn = 1'b0; regAddr = rdA;
    #1;
    check(curReq, "pinOut", {15'd0, pinOut}, {15'd0, expPin()});
    check(curReq, "oe", {15'd0, oe}, {15'd0, expOe()});
    check(curReq, "rdData", regRdData, expRead(rdA));
  endtask

  task automatic idle(input int n, input logic [1:0] rdA);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'd0, rdA);
  endtask

  function automatic logic [15:0] ctl(input logic [7:0] pre, input logic en, input logic pol,
                                      input logic dir, input logic tr, input logic fz);
    return {3'b000, fz, tr, dir, pol, en, pre};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    int highs;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R10: reset state
    curReq = "R10";
    for (int a = 0; a < 4; a++) begin
      regAddr = a[1:0]; #1;
      check("R10", "reset read", regRdData, 16'd0);
    end
    check("R10", "reset oe", {15'd0, oe}, 16'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1/R5: fast prescaler, period 4 width 2, high pulse
    curReq = "R5";
    cyc(1, 2'd0, 16'd4, 2'd2);
    cyc(1, 2'd1, 16'd2, 2'd2);
    cyc(1, 2'd3, ctl(8'hFF, 0, 1, 0, 0, 0), 2'd2);
    cyc(1, 2'd3, ctl(8'hFF, 1, 1, 0, 0, 0), 2'd2);
    idle(10, 2'd2);
    highs = 0;
    for (int i = 0; i < 8; i++) begin
      idle(1, 2'd2);
      highs += pinOut;
    end
    check("R5", "high count in two periods", highs[15:0], 16'd4);
    cyc(1, 2'd2, 16'h00AA, 2'd2);
    idle(6, 2'd2);

    // R1: divide by 3
    curReq = "R1";
    cyc(1, 2'd3, ctl(8'hFD, 1, 1, 0, 0, 0), 2'd3);
    idle(40, 2'd2);

    // R2: buffered period/width change mid-period
    curReq = "R2";
    cyc(1, 2'd0, 16'd6, 2'd0);
    cyc(1, 2'd1, 16'd5, 2'd1);
    idle(40, 2'd2);

    // R6: width 0 and width beyond period
    curReq = "R6";
    cyc(1, 2'd1, 16'd0, 2'd2);
    idle(30, 2'd2);
    check("R6", "zero width inactive", {15'd0, pinOut}, 16'd0);
    cyc(1, 2'd1, 16'd9, 2'd2);
    idle(30, 2'd2);
    check("R6", "wide width active", {15'd0, pinOut}, 16'd1);
    cyc(1, 2'd1, 16'd6, 2'd2);
    idle(30, 2'd2);

    // R7: low-going pulse, direction bit ignored while enabled
    curReq = "R7";
    cyc(1, 2'd1, 16'd2, 2'd2);
    cyc(1, 2'd3, ctl(8'hFF, 1, 0, 0, 0, 0), 2'd2);
    idle(30, 2'd2);
    check("R7", "oe while enabled dir=0", {15'd0, oe}, 16'd1);

    // R3: transparent writes
    curReq = "R3";
    cyc(1, 2'd3, ctl(8'hFE, 1, 1, 0, 1, 0), 2'd2);
    cyc(1, 2'd0, 16'd3, 2'd2);
    cyc(1, 2'd1, 16'd1, 2'd2);
    idle(25, 2'd2);
    cyc(1, 2'd0, 16'd8, 2'd2);
    idle(25, 2'd2);

    // R4: freeze honored, then ignored
    curReq = "R4";
    cyc(1, 2'd3, ctl(8'hFF, 1, 1, 0, 0, 1), 2'd2);
    idle(5, 2'd2);
    freezeIn = 1'b1;
    idle(20, 2'd2);
    cyc(1, 2'd3, ctl(8'hFF, 1, 1, 0, 0, 0), 2'd2);
    idle(20, 2'd2);
    freezeIn = 1'b0;

    // R8: disabled pin modes
    curReq = "R8";
    cyc(1, 2'd3, ctl(8'hFF, 0, 1, 1, 0, 0), 2'd2);
    idle(5, 2'd2);
    check("R8", "driven high", {15'd0, pinOut}, 16'd1);
    cyc(1, 2'd3, ctl(8'hFF, 0, 0, 1, 0, 0), 2'd2);
    idle(5, 2'd2);
    cyc(1, 2'd3, ctl(8'hFF, 0, 0, 0, 0, 0), 2'd3);
    check("R8", "input oe", {15'd0, oe}, 16'd0);

    // R9: status reflects the external level, write ignored
    curReq = "R9";
    extLvl = 1'b1; idle(2, 2'd3);
    extLvl = 1'b0;
    cyc(1, 2'd3, 16'h8000, 2'd3);
    check("R9", "status bit after write", {15'd0, regRdData[15]}, 16'd0);
    extLvl = 1'b1; idle(2, 2'd3);

    // random mix
    curReq = "R5";
    for (int i = 0; i < 4000; i++) begin
      int unsigned r;
      logic [7:0] pres [4];
      pres[0] = 8'hFF; pres[1] = 8'hFE; pres[2] = 8'hFC; pres[3] = 8'hF8;
      r = $urandom % 100;
      freezeIn = ($urandom % 8) == 0;
      extLvl = $urandom % 2;
      if (r < 4)
        cyc(1, 2'd3, ctl(pres[$urandom % 4], ($urandom % 8) != 0, $urandom % 2,
                         $urandom % 2, ($urandom % 4) == 0, $urandom % 2), 2'($urandom % 4));
      else if (r < 8)
        cyc(1, 2'd0, 16'($urandom % 12 + 1), 2'($urandom % 4));
      else if (r < 12)
        cyc(1, 2'd1, 16'($urandom % 15), 2'($urandom % 4));
      else
        cyc(0, 2'd0, 16'd0, 2'($urandom % 4));
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule